// File: doc/BRIEF.md
# Two-Lane Power-State Change Sequencer

This block carries out one power-state change on a PHY with two lanes. A start pulse captures a lane-select mask and a 4-bit target power state. The sequencer then writes the target into the new-state field of every selected lane in a 32-bit control image. One cycle later it raises the update bit of each selected lane. It then waits until the PHY has cleared every selected update bit. The PHY clears a lane's update bit by asserting that lane's acknowledge input.

The wait is limited by a count of microsecond ticks, so its length does not depend on the clock frequency. If the limit runs out, the sequencer raises a sticky warning flag and still reports completion. It does not abort. Each change, normal or expired, ends with a single-cycle done pulse.

The package names the power-state codes the PHY understands:
- `0x0`: active.
- `0x2`: ready, also used as the reset state.
- `0x9`: powered off from ready.
- `0xC`: powered off from the deepest state.

Top module: `lane_pstate_seq`

## Requirements
- R1: After reset the control image is all zeros, done is low and the timeout flag is low.
- R2: The lane-select mask has bit 0 for lane 0 and bit 1 for lane 1, so 01, 10 and 11 are valid codes. The lane-0 new-state field is image bits 23:20 and the lane-1 field is bits 19:16. A start accepted at clock edge E writes the target state into the selected fields at edge E+1.
- R3: The update bits are bit 25 for lane 0 and bit 24 for lane 1. They are set at edge E+2 for the selected lanes only, which is one edge after the fields are written.
- R4: The new-state field and the update bit of a lane that is not selected keep their values through the whole change.
- R5: While the acknowledge input of a lane is high, that lane's update bit clears at the next edge. The only exception is the arming edge, where setting the bit takes precedence.
- R6: In the waiting phase, the first edge that sees every selected update bit at 0 drives done high for exactly one cycle. With acknowledge already high at start, done is visible in the fifth cycle after the start cycle.
- R7: The timeout counter advances only on edges where the microsecond tick is high while waiting. The tick that would make TIMEOUT_US ticks (default 5) without completion sets the timeout flag and pulses done. The update bits are left as they are.
- R8: The timeout flag stays high until the next accepted start, and it clears at that start's edge.
- R9: A start pulse while a change is in progress is ignored, as is a start with a lane mask of 00. Neither changes the image, done or the flag.
- R10: If completion and the final tick fall on the same edge, completion wins and the timeout flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a change when idle |
| laneSel | input | 2 | Lane mask: bit 0 is lane 0, bit 1 is lane 1 |
| targetState | input | 4 | Power-state code to apply |
| usTick | input | 1 | One-cycle pulse per microsecond |
| phyUpdAck | input | 2 | PHY clears the update bit of lane i while bit i is high |
| ctrlWord | output | 32 | Control image driven to the PHY |
| done | output | 1 | One-cycle completion pulse |
| timeoutFlag | output | 1 | Sticky warning: acknowledge wait expired |

## Verification
The bench builds the block with its default parameters: two lanes, 4-bit states and a 5-tick limit. With a tick on every cycle, the full timeout window fits in a few cycles. That makes the expiry edge reachable, along with the case where an acknowledge lands exactly on the last tick. A behavioural model follows the capture, write, arm and wait phases and is compared with the image, done and the flag every cycle. This exposes any slip of one cycle in field writes, arming or completion.

// File: rtl/lane_pstate_pkg.sv
package lane_pstate_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_ARM   = 2'd2,
    PH_WAIT  = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic writeFields;
    logic armUpdate;
  } dpStrobe_t;

  // Power-state codes understood by the PHY
  localparam logic [3:0] PST_ACTIVE         = 4'h0;
  localparam logic [3:0] PST_READY          = 4'h2;
  localparam logic [3:0] PST_OFF_FROM_READY = 4'h9;
  localparam logic [3:0] PST_OFF_DEEP       = 4'hC;

endpackage

// File: rtl/lane_pstate_ctrl.sv
module lane_pstate_ctrl
  import lane_pstate_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int STATE_W    = 4,
  parameter int TIMEOUT_US = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LANES-1:0]   laneSel,
  input  logic [STATE_W-1:0] targetState,
  input  logic               usTick,
  input  logic [LANES-1:0]   updPending,
  output dpStrobe_t          strobe,
  output logic [LANES-1:0]   selQ,
  output logic [STATE_W-1:0] stateQ,
  output logic               done,
  output logic               timeoutFlag
);

  localparam int CNT_W = $clog2(TIMEOUT_US + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TIMEOUT_US - 1);

  phase_e            phase;
  logic [CNT_W-1:0]  usCnt;
  logic              acceptStart;
  logic              allClear;

  assign acceptStart = (phase == PH_IDLE) && start && (|laneSel);
  assign allClear    = ((updPending & selQ) == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      selQ        <= '0;
      stateQ      <= '0;
      usCnt       <= '0;
      done        <= 1'b0;
      timeoutFlag <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (acceptStart) begin
            selQ        <= laneSel;
            stateQ      <= targetState;
            timeoutFlag <= 1'b0;
            phase       <= PH_WRITE;
          end
        end
        PH_WRITE: phase <= PH_ARM;
        PH_ARM: begin
          usCnt <= '0;
          phase <= PH_WAIT;
        end
        PH_WAIT: begin
          if (allClear) begin
            done  <= 1'b1;
            phase <= PH_IDLE;
          end else if (usTick) begin
            if (usCnt == LAST_CNT) begin
              timeoutFlag <= 1'b1;
              done        <= 1'b1;
              phase       <= PH_IDLE;
            end else begin
              usCnt <= usCnt + 1'b1;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.writeFields = (phase == PH_WRITE);
    strobe.armUpdate   = (phase == PH_ARM);
  end

  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: the tick counter never exceeds the window
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    usCnt < CNT_W'(TIMEOUT_US));

  // R8: the warning holds until a start is accepted
  a_r8_flag_held: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !acceptStart) |=> timeoutFlag);

  // R9: the captured request is frozen while busy
  a_r9_latch_stable: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> ($stable(selQ) && $stable(stateQ)));

  // R3: arming always follows a field write
  a_r3_arm_after_write: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armUpdate |-> $past(strobe.writeFields));

endmodule

// File: rtl/lane_pstate_dp.sv
module lane_pstate_dp
  import lane_pstate_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int STATE_W    = 4,
  parameter int WORD_W     = 32,
  parameter int FIELD0_LSB = 20,
  parameter int UPD0_BIT   = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [LANES-1:0]   selQ,
  input  logic [STATE_W-1:0] stateQ,
  input  logic [LANES-1:0]   phyUpdAck,
  output logic [LANES-1:0]   updPending,
  output logic [WORD_W-1:0]  ctrlWord
);

  logic [STATE_W-1:0] fieldQ [LANES];
  logic [LANES-1:0]   updQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) fieldQ[i] <= '0;
      updQ <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (strobe.writeFields && selQ[i]) fieldQ[i] <= stateQ;
        if (strobe.armUpdate && selQ[i]) updQ[i] <= 1'b1;
        else if (phyUpdAck[i])           updQ[i] <= 1'b0;
      end
    end
  end

  // Lane i field sits STATE_W bits below lane i-1; update bits descend by one
  always_comb begin
    ctrlWord = '0;
    for (int i = 0; i < LANES; i++) begin
      ctrlWord[FIELD0_LSB - i*STATE_W +: STATE_W] = fieldQ[i];
      ctrlWord[UPD0_BIT - i]                      = updQ[i];
    end
  end

  assign updPending = updQ;

  for (genvar g = 0; g < LANES; g++) begin : g_laneChk
    // R4: an unselected lane's field is not written
    a_r4_unsel_field: assert property (@(posedge clk) disable iff (!rstN)
      (!selQ[g] || !strobe.writeFields) |=> $stable(fieldQ[g]));
    // R5: acknowledge clears the update bit outside the arming edge
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
      (phyUpdAck[g] && !(strobe.armUpdate && selQ[g])) |=> !updQ[g]);
  end

endmodule

// File: rtl/lane_pstate_seq.sv
module lane_pstate_seq
  import lane_pstate_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int STATE_W    = 4,
  parameter int WORD_W     = 32,
  parameter int FIELD0_LSB = 20,
  parameter int UPD0_BIT   = 25,
  parameter int TIMEOUT_US = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LANES-1:0]   laneSel,
  input  logic [STATE_W-1:0] targetState,
  input  logic               usTick,
  input  logic [LANES-1:0]   phyUpdAck,
  output logic [WORD_W-1:0]  ctrlWord,
  output logic               done,
  output logic               timeoutFlag
);

  dpStrobe_t          strobe;
  logic [LANES-1:0]   selQ;
  logic [STATE_W-1:0] stateQ;
  logic [LANES-1:0]   updPending;

  lane_pstate_ctrl #(
    .LANES(LANES), .STATE_W(STATE_W), .TIMEOUT_US(TIMEOUT_US)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .laneSel(laneSel),
    .targetState(targetState), .usTick(usTick), .updPending(updPending),
    .strobe(strobe), .selQ(selQ), .stateQ(stateQ), .done(done),
    .timeoutFlag(timeoutFlag)
  );

  lane_pstate_dp #(
    .LANES(LANES), .STATE_W(STATE_W), .WORD_W(WORD_W),
    .FIELD0_LSB(FIELD0_LSB), .UPD0_BIT(UPD0_BIT)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selQ(selQ), .stateQ(stateQ),
    .phyUpdAck(phyUpdAck), .updPending(updPending), .ctrlWord(ctrlWord)
  );

endmodule

// File: tb/lane_pstate_seq_tb.sv
module lane_pstate_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TO_US      = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  laneSel = 2'b00;
  logic [3:0]  targetState = 4'h0;
  logic        usTick = 1'b0;
  logic [1:0]  phyUpdAck = 2'b00;
  logic [31:0] ctrlWord;
  logic        done;
  logic        timeoutFlag;

  int    tests = 0;
  int    fails = 0;
  string curReq = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_pstate_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .laneSel(laneSel),
    .targetState(targetState), .usTick(usTick), .phyUpdAck(phyUpdAck),
    .ctrlWord(ctrlWord), .done(done), .timeoutFlag(timeoutFlag)
  );

  // Behavioural reference: phase number, captured request, lane fields
  int         mPh, oldPh, mCnt;
  logic [1:0] mSel, mU, oldU;
  logic [3:0] mSt;
  logic [3:0] mF [2];
  logic       mDone, mTo;

  function automatic logic [31:0] modelWord();
    return {6'b0, mU[0], mU[1], mF[0], mF[1], 16'h0};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPh = 0; mCnt = 0; mSel = 0; mU = 0; mSt = 0;
      mF[0] = 0; mF[1] = 0; mDone = 0; mTo = 0;
    end else begin
      oldU = mU; oldPh = mPh; mDone = 0;
      case (mPh)
        0: if (start && laneSel != 2'b00) begin
             mSel = laneSel; mSt = targetState; mTo = 0; mPh = 1;
           end
        1: begin
             for (int l = 0; l < 2; l++) if (mSel[l]) mF[l] = mSt;
             mPh = 2;
           end
        2: begin mCnt = 0; mPh = 3; end
        default: begin
          if ((oldU & mSel) == 2'b00) begin
            mDone = 1; mPh = 0;
          end else if (usTick) begin
            if (mCnt == TO_US - 1) begin mTo = 1; mDone = 1; mPh = 0; end
            else mCnt++;
          end
        end
      endcase
      for (int l = 0; l < 2; l++) begin
        if (oldPh == 2 && mSel[l]) mU[l] = 1'b1;
        else if (phyUpdAck[l])     mU[l] = 1'b0;
      end
    end
  end

  // Cycle-by-cycle comparison just after each edge
  always @(posedge clk) begin
    #1;
    tests++;
    if (ctrlWord !== modelWord() || done !== mDone || timeoutFlag !== mTo) begin
      fails++;
      $display("FAIL %s per-cycle: word=%h done=%b to=%b expected word=%h done=%b to=%b",
               curReq, ctrlWord, done, timeoutFlag, modelWord(), mDone, mTo);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one change; doneAt counts negedges after the start cycle
  task automatic opRun(input logic [1:0] sel, input logic [3:0] st, input int ackAt,
                       input int tickEvery, output int doneAt);
    doneAt = -1;
    @(negedge clk);
    start = 1'b1; laneSel = sel; targetState = st;
    usTick = (tickEvery == 1);
    phyUpdAck = (ackAt == 0) ? 2'b11 : 2'b00;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin doneAt = k; break; end
      usTick = (tickEvery > 0) && (k % tickEvery == 0);
      phyUpdAck = (ackAt >= 0 && k >= ackAt) ? 2'b11 : 2'b00;
    end
    usTick = 1'b0; phyUpdAck = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog: actual=no finish expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 reset word", ctrlWord, 32'h0);
    check("R1 reset done/flag", {30'b0, done, timeoutFlag}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Both lanes to ready, acknowledge held from start
    curReq = "R2";
    opRun(2'b11, 4'h2, 0, 0, d);
    check("R6 done latency", d, 5);
    check("R2 both fields", ctrlWord, 32'h0022_0000);

    // Lane 0 only, power off from ready
    curReq = "R4";
    opRun(2'b01, 4'h9, 3, 0, d);
    check("R4 lane1 kept", ctrlWord, 32'h0092_0000);

    // Lane 1 only, deepest off, late acknowledge
    curReq = "R3";
    opRun(2'b10, 4'hC, 7, 0, d);
    check("R3 lane1 field", ctrlWord, 32'h009C_0000);
    check("R6 late ack latency", d, 9);

    // Timeout: tick every cycle, no acknowledge
    curReq = "R7";
    opRun(2'b11, 4'h0, -1, 1, d);
    check("R7 timeout edge", d, 8);
    check("R7 flag set", {31'b0, timeoutFlag}, 32'h1);
    check("R7 update bits left", ctrlWord, 32'h0300_0000);
    repeat (4) @(negedge clk);
    curReq = "R8";
    check("R8 flag held", {31'b0, timeoutFlag}, 32'h1);

    // Zero lane mask ignored, flag stays
    curReq = "R9";
    start = 1'b1; laneSel = 2'b00; targetState = 4'h9;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 zero mask word", ctrlWord, 32'h0300_0000);
    check("R9 zero mask flag", {31'b0, timeoutFlag}, 32'h1);

    // Next start clears the flag at its own edge
    curReq = "R8";
    start = 1'b1; laneSel = 2'b11; targetState = 4'h2;
    @(negedge clk);
    start = 1'b0;
    check("R8 flag cleared", {31'b0, timeoutFlag}, 32'h0);
    phyUpdAck = 2'b11;
    repeat (8) @(negedge clk);
    phyUpdAck = 2'b00;
    curReq = "R5";
    check("R5 bits cleared", ctrlWord, 32'h0022_0000);

    // Start while busy is ignored
    curReq = "R9";
    start = 1'b1; laneSel = 2'b11; targetState = 4'h0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; laneSel = 2'b01; targetState = 4'hF;
    @(negedge clk);
    start = 1'b0; phyUpdAck = 2'b11;
    repeat (6) @(negedge clk);
    phyUpdAck = 2'b00;
    check("R9 busy start ignored", ctrlWord, 32'h0000_0000);

    // Acknowledge lands on the final tick: completion wins
    curReq = "R10";
    opRun(2'b11, 4'h2, 6, 1, d);
    check("R10 done edge", d, 8);
    check("R10 no timeout", {31'b0, timeoutFlag}, 32'h0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule